// File: doc/BRIEF.md
# Character Terminal Register Interface

This block connects a character terminal to a processor bus as three memory-mapped registers: a keyboard data register, a display data register and a combined status/control register. An address decoder picks one of the three on each bus access; reads and writes complete in one cycle, and read data appears on the cycle after the read strobe.

Keyboard characters arrive over a valid-only strobe and are held in a single register. Display characters leave over a valid/ready handshake. Software can busy-wait on the two ready flags in the status register. It can also set an enable bit in that register, so that a pending keyboard character raises an interrupt request. The processor acknowledges that request to drop it.

Top module: `term_port`

## Requirements
- R1: After reset the input-ready, overrun and interrupt-enable bits are 0, the output-ready bit is 1, `irq` and `disp_valid` are low, and `bus_rdata` is 0.
- R2: With default parameters the keyboard register is at address 0, the display register at address 1 and the status register at address 2. A read presents its data on `bus_rdata` in the cycle after `bus_rd`. A read at any other address, or a cycle with no read, gives 0.
- R3: Status read layout: bit 0 is output-ready, bit 1 is input-ready, bit 2 is overrun and bit 6 is interrupt-enable. All other bits read 0.
- R4: A cycle with `kbd_valid` high stores `kbd_data` and sets input-ready on the next cycle.
- R5: A read of the keyboard register returns the stored character and clears input-ready. If a new character arrives in that same cycle, the read returns the old character, the new one is stored, input-ready stays 1 and overrun is not set.
- R6: A character that arrives while input-ready is 1, in a cycle without a keyboard-register read, replaces the stored character and sets overrun.
- R7: A status read clears overrun. If an overrun event falls in the same cycle, overrun stays 1, and the read returns the value from before that cycle.
- R8: A status write loads bit 6 of the write data into interrupt-enable and changes no other status bit.
- R9: A display-register write while output-ready is 1 captures the data, clears output-ready and raises `disp_valid` with that data, held stable until taken. A display write while output-ready is 0 is dropped.
- R10: A cycle with `disp_valid` and `disp_ready` both high sets output-ready and lowers `disp_valid` on the next cycle.
- R11: `irq` is high only while interrupt-enable and input-ready are both 1. An `irq_ack` while `irq` is high lowers `irq` on the next cycle, and `irq` stays low until a new character arrives.
- R12: Writes to the keyboard register address and to undecoded addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the strobe |
| kbd_valid | input | 1 | Keyboard character strobe |
| kbd_data | input | 8 | Keyboard character |
| disp_valid | output | 1 | Display character available |
| disp_data | output | 8 | Display character |
| disp_ready | input | 1 | Display takes the character |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
Two pairs of events can fall in the same cycle. A keyboard arrival can coincide with a keyboard-register read, and an overrun-causing arrival can coincide with a status read. The bench forces each collision by raising the bus strobe and `kbd_valid` on the same cycle. In each case it checks that the read returns the value from before the cycle, and that a follow-up status read shows the arrival winning: input-ready still set without overrun in the first case, overrun still set in the second.

// File: rtl/term_port.sv
module term_port #(
  parameter int ADDR_W   = 4,
  parameter int KBD_ADR  = 0,
  parameter int DISP_ADR = 1,
  parameter int STAT_ADR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              kbd_valid,
  input  logic [7:0]        kbd_data,
  output logic              disp_valid,
  output logic [7:0]        disp_data,
  input  logic              disp_ready,
  output logic              irq,
  input  logic              irq_ack
);
  localparam logic [ADDR_W-1:0] A_KBD  = ADDR_W'(KBD_ADR);
  localparam logic [ADDR_W-1:0] A_DISP = ADDR_W'(DISP_ADR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADR);

  logic [7:0] kbd_q, disp_q;
  logic       in_rdy, out_rdy, ovr, ie, ackd;

  wire sel_kbd  = bus_addr == A_KBD;
  wire sel_disp = bus_addr == A_DISP;
  wire sel_stat = bus_addr == A_STAT;

  wire rd_kbd  = bus_rd && sel_kbd;
  wire rd_stat = bus_rd && sel_stat;
  wire wr_disp = bus_wr && sel_disp;
  wire wr_stat = bus_wr && sel_stat;
  wire take    = disp_valid && disp_ready;

  wire [7:0] status = {1'b0, ie, 3'b000, ovr, in_rdy, out_rdy};

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_rd) begin
      if (sel_kbd)       rd_mux = kbd_q;
      else if (sel_disp) rd_mux = disp_q;
      else if (sel_stat) rd_mux = status;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      kbd_q     <= '0;
      disp_q    <= '0;
      in_rdy    <= 1'b0;
      out_rdy   <= 1'b1;
      ovr       <= 1'b0;
      ie        <= 1'b0;
      ackd      <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;

      if (kbd_valid) begin
        kbd_q  <= kbd_data;
        in_rdy <= 1'b1;
      end else if (rd_kbd) begin
        in_rdy <= 1'b0;
      end

      if (kbd_valid && in_rdy && !rd_kbd) ovr <= 1'b1;
      else if (rd_stat)                   ovr <= 1'b0;

      if (wr_stat) ie <= bus_wdata[6];

      if (wr_disp && out_rdy) begin
        disp_q  <= bus_wdata;
        out_rdy <= 1'b0;
      end else if (take) begin
        out_rdy <= 1'b1;
      end

      if (kbd_valid)          ackd <= 1'b0;
      else if (irq && irq_ack) ackd <= 1'b1;
      else if (!in_rdy)       ackd <= 1'b0;
    end
  end

  assign disp_valid = !out_rdy;
  assign disp_data  = disp_q;
  assign irq        = ie && in_rdy && !ackd;
endmodule

// File: rtl/term_port_chk.sv
module term_port_chk #(
  parameter int ADDR_W   = 4,
  parameter int KBD_ADR  = 0,
  parameter int STAT_ADR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              kbd_valid,
  input logic              disp_valid,
  input logic [7:0]        disp_data,
  input logic              disp_ready,
  input logic              irq,
  input logic              irq_ack,
  input logic              in_rdy,
  input logic              ovr,
  input logic              ie
);
  // R4
  arrival_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid |=> in_rdy);

  // R6
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && in_rdy && !(bus_rd && bus_addr == ADDR_W'(KBD_ADR)) |=> ovr);

  // R8
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(STAT_ADR) |=> ie == $past(bus_wdata[6]));

  // R9
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_data));

  // R10
  disp_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> !disp_valid);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie && in_rdy);

  // R11
  irq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && irq_ack && !kbd_valid |=> !irq);
endmodule

bind term_port term_port_chk #(
  .ADDR_W(ADDR_W), .KBD_ADR(KBD_ADR), .STAT_ADR(STAT_ADR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .kbd_valid(kbd_valid),
  .disp_valid(disp_valid), .disp_data(disp_data), .disp_ready(disp_ready),
  .irq(irq), .irq_ack(irq_ack), .in_rdy(in_rdy), .ovr(ovr), .ie(ie)
);

// File: tb/term_port_test.sv
module term_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       kbd_valid = 0;
  logic [7:0] kbd_data = '0;
  logic       disp_valid;
  logic [7:0] disp_data;
  logic       disp_ready = 0;
  logic       irq;
  logic       irq_ack = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [3:0] KBD = 4'd0, DISP = 4'd1, STAT = 4'd2;

  always #4 clk = ~clk;

  term_port uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk); kbd_valid = 1; kbd_data = c;
    @(negedge clk); kbd_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 disp_valid", {7'b0, disp_valid}, 8'h00);
    rd(STAT, d); chk("R1 status", d, 8'h01);
  endtask

  task automatic t_poll;
    logic [7:0] d;
    key(8'h41);
    rd(STAT, d); chk("R4 R3 status after key", d, 8'h03);
    rd(KBD, d);  chk("R5 kbd data", d, 8'h41);
    rd(STAT, d); chk("R5 ready cleared", d, 8'h01);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    key(8'h11); key(8'h22);
    rd(STAT, d); chk("R6 overrun set", d, 8'h07);
    rd(STAT, d); chk("R7 overrun cleared", d, 8'h03);
    rd(KBD, d);  chk("R6 newest kept", d, 8'h22);
  endtask

  task automatic t_read_vs_arrival;
    logic [7:0] d;
    key(8'h33);
    @(negedge clk); bus_rd = 1; bus_addr = KBD; kbd_valid = 1; kbd_data = 8'h44;
    @(negedge clk); bus_rd = 0; kbd_valid = 0;
    chk("R5 collision returns old", bus_rdata, 8'h33);
    rd(STAT, d); chk("R5 collision ready kept, no overrun", d, 8'h03);
    rd(KBD, d);  chk("R5 collision new stored", d, 8'h44);
  endtask

  task automatic t_status_vs_overrun;
    logic [7:0] d;
    key(8'h55); key(8'h66);
    @(negedge clk); bus_rd = 1; bus_addr = STAT; kbd_valid = 1; kbd_data = 8'h77;
    @(negedge clk); bus_rd = 0; kbd_valid = 0;
    chk("R7 collision returns old", bus_rdata, 8'h07);
    rd(STAT, d); chk("R7 overrun kept", d, 8'h07);
    rd(STAT, d); chk("R7 overrun cleared", d, 8'h03);
    rd(KBD, d);  chk("R6 latest char", d, 8'h77);
  endtask

  task automatic t_status_write;
    logic [7:0] d;
    wr(STAT, 8'hFF);
    rd(STAT, d); chk("R8 only enable set", d, 8'h41);
    wr(STAT, 8'hBF);
    rd(STAT, d); chk("R8 enable cleared", d, 8'h01);
  endtask

  task automatic t_display;
    logic [7:0] d;
    disp_ready = 0;
    wr(DISP, 8'h5A);
    chk("R9 disp_valid", {7'b0, disp_valid}, 8'h01);
    chk("R9 disp_data", disp_data, 8'h5A);
    rd(STAT, d); chk("R9 out ready cleared", d, 8'h00);
    wr(DISP, 8'h77);
    chk("R9 busy write dropped", disp_data, 8'h5A);
    @(negedge clk); disp_ready = 1;
    @(negedge clk); disp_ready = 0;
    chk("R10 disp_valid falls", {7'b0, disp_valid}, 8'h00);
    rd(STAT, d); chk("R10 out ready set", d, 8'h01);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(STAT, 8'h40);
    chk("R11 no irq idle", {7'b0, irq}, 8'h00);
    key(8'h0D);
    chk("R11 irq raised", {7'b0, irq}, 8'h01);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R11 irq dropped on ack", {7'b0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R11 irq stays low", {7'b0, irq}, 8'h00);
    key(8'h0E);
    chk("R11 irq re-raised by new char", {7'b0, irq}, 8'h01);
    rd(KBD, d);
    chk("R11 irq low after read", {7'b0, irq}, 8'h00);
    rd(STAT, d); chk("R3 status with enable", d, 8'h45);
    wr(STAT, 8'h00);
    key(8'h21);
    chk("R11 disabled no irq", {7'b0, irq}, 8'h00);
    rd(KBD, d);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    rd(4'd5, d); chk("R2 undecoded read", d, 8'h00);
    rd(DISP, d); chk("R2 display readback", d, 8'h5A);
    wr(KBD, 8'h99);
    wr(4'd5, 8'hFF);
    rd(STAT, d); chk("R12 status unchanged", d, 8'h01);
    rd(KBD, d);  chk("R12 kbd unchanged", d, 8'h21);
    chk("R12 no display", {7'b0, disp_valid}, 8'h00);
    @(negedge clk); chk("R2 idle rdata zero", bus_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_poll();
    t_overrun();
    t_read_vs_arrival();
    t_status_vs_overrun();
    t_status_write();
    t_display();
    t_irq();
    t_decode();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule